// File: doc/BRIEF.md
# Command-Driven HDLC Frame Transmitter

This block turns bytes queued by a host into a bit-serial channel stream. The host pushes bytes into an internal transmit queue and controls transmission by writing a small command register. The command bits are write-only and clear themselves. One serial bit leaves the block for every clock cycle in which the channel's bit-enable strobe is high.

Two line formats are supported. In the framed format the block wraps the queued bytes in a frame. It sends an opening flag, inserts a zero after every run of five ones, and finishes the frame with a CRC-16 check sequence and a closing flag. Between frames the line carries continuous flags. In the raw format the queued bits go out untouched, and the idle line is all ones.

The host can refill the queue and re-issue the start command in the middle of a frame to continue that same frame. A level interrupt tells it when enough queue space is free, measured against a programmable threshold. If the queue runs dry inside a frame before the end command arrives, the block aborts the frame and flags an underrun.

Top module: `hdlc_cmd_tx`

## Requirements
- R1: A command write latches `cmd_data` (bit 0 = end-of-frame, bit 1 = start/continue, bit 2 = transmitter reset) for exactly one cycle. A bit written as 0 has no effect. A single write therefore produces at most one frame.
- R2: In framed mode, a start command issued while idle sends an opening flag 0x7E, then the queued bytes, each byte least-significant bit first.
- R3: Inside a framed frame, a 0 is inserted after every five consecutive 1s of data and check sequence. Flags are never stuffed.
- R4: After an end-of-frame command, the block drains the remaining queued bytes. It then sends the ones-complemented CRC-16 (polynomial 0x1021, preset 0xFFFF, reflected) low byte first, followed by a closing flag.
- R5: A start command issued during an active frame continues that frame and sends no new opening flag.
- R6: An end-of-frame command issued while idle is ignored.
- R7: In raw mode (`raw_mode` = 1), a start command sends the queued bytes LSB first with no flag, check sequence or zero insertion. The idle line is constant 1.
- R8: If the queue empties during a framed frame before an end command, `underrun` pulses high for one cycle, at least seven 1s are sent, and the line returns to idle flags.
- R9: A transmitter reset command empties the queue and returns the serializer to idle flags without an underrun.
- R10: `space_irq` is high exactly when the number of free queue bytes is greater than or equal to `space_thr`.
- R11: In framed mode with no frame pending, the line repeats the flag 0x7E. After reset `txd` is 1.
- R12: `txd` changes only on a clock edge at which `bit_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push `wr_data` into the transmit queue (dropped when full) |
| wr_data | input | 8 | Byte to queue |
| cmd_we | input | 1 | Command register write strobe |
| cmd_data | input | 3 | Command bits: 0 end-of-frame, 1 start/continue, 2 transmitter reset |
| raw_mode | input | 1 | 1 selects raw format, 0 selects framed format |
| space_thr | input | 7 | Free-space threshold for the interrupt |
| bit_en | input | 1 | Channel bit strobe; one bit advances per high cycle |
| txd | output | 1 | Serial output |
| space_irq | output | 1 | Free space at or above threshold |
| underrun | output | 1 | One-cycle pulse when a frame is aborted for lack of data |

## Verification
The bench decodes the serial line with its own flag, unstuffing and abort detector. It rebuilds each frame and compares the payload and check sequence against values it computes itself. Frames of random length and content are sent under strobe densities from sparse to continuous, which separates correct bit pacing from logic that runs ahead of the strobe. Payloads rich in 0xFF and 0x7E isolate zero insertion, because any missed stuff bit shows up as a false flag or abort. A split frame with a mid-frame continue, an end issued while idle followed by a starved frame, a reset during a frame, and a raw run each expose one specific path: a spurious opening flag, a latched stale end, leftover queue contents, and stuffing or framing that leaks into raw mode.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    localparam logic [7:0]  FLAG_BYTE    = 8'h7E;
    localparam logic [15:0] CRC_PRESET   = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_REV = 16'h8408;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_BODY,
        PH_FCS
    } tx_phase_e;

    // command register image: bit 2 reset, bit 1 start/continue, bit 0 end
    typedef struct packed {
        logic txrst;
        logic start;
        logic fin;
    } tx_cmd_t;

    // one unit of serial output: a flag, a byte, the check sequence or an abort
    typedef struct packed {
        logic [15:0] bits;
        logic [4:0]  len;
        logic        stuff;
        logic        fcs_feed;
    } tx_unit_t;

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic fb;
        logic [15:0] n;
        fb = c[0] ^ b;
        n  = c >> 1;
        if (fb) n = n ^ CRC_POLY_REV;
        return n;
    endfunction

    function automatic tx_unit_t mk_unit(input logic [15:0] b, input logic [4:0] n,
                                         input logic s, input logic f);
        tx_unit_t u;
        u.bits     = b;
        u.len      = n;
        u.stuff    = s;
        u.fcs_feed = f;
        return u;
    endfunction

endpackage

// File: rtl/hdlc_cmd_reg.sv
module hdlc_cmd_reg
    import hdlc_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_we,
    input  logic [2:0] cmd_data,
    output tx_cmd_t    cmd_q
);

    // each written 1 lives for one cycle; a written 0 leaves nothing behind
    always_ff @(posedge clk) begin
        if (rst)         cmd_q <= '0;
        else if (cmd_we) cmd_q <= tx_cmd_t'(cmd_data);
        else             cmd_q <= '0;
    end

endmodule

// File: rtl/tx_byte_fifo.sv
module tx_byte_fifo #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             pop,
    output logic [7:0]       rd_data,
    output logic             empty,
    output logic [CNT_W-1:0] fill
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             wr_ok, rd_ok;

    assign empty   = (fill == '0);
    assign wr_ok   = wr_en && (fill != CNT_W'(DEPTH));
    assign rd_ok   = pop && !empty;
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
        end else begin
            if (wr_ok) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (rd_ok) rp <= (rp == LAST) ? '0 : rp + 1'b1;
            case ({wr_ok, rd_ok})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/hdlc_tx_serial.sv
module hdlc_tx_serial
    import hdlc_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       raw_mode,
    input  logic       start_p,
    input  logic       fin_p,
    input  logic       bit_en,
    input  logic       fifo_empty,
    input  logic [7:0] fifo_data,
    output logic       fifo_pop,
    output logic       txd,
    output logic       underrun
);

    localparam tx_unit_t FLAG_U = mk_unit({8'h00, FLAG_BYTE}, 5'd8, 1'b0, 1'b0);
    localparam tx_unit_t ONES_U = mk_unit(16'h00FF, 5'd8, 1'b0, 1'b0);

    tx_unit_t    cur_q, nxt_unit, src;
    tx_phase_e   phase_q, nxt_phase;
    logic        raw_act_q, nxt_raw;
    logic        start_pend_q, fin_pend_q;
    logic [2:0]  ones_q;
    logic [15:0] crc_q;
    logic        txd_q, urun_q;
    logic        take_byte, use_start, use_fin, raise_urun, crc_seed;
    logic        stuff_now, load, out_bit;

    // choose the unit that follows once the current one is used up
    always_comb begin
        nxt_unit   = raw_mode ? ONES_U : FLAG_U;
        nxt_phase  = phase_q;
        nxt_raw    = raw_act_q;
        take_byte  = 1'b0;
        use_start  = 1'b0;
        use_fin    = 1'b0;
        raise_urun = 1'b0;
        crc_seed   = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (start_pend_q) begin
                    if (raw_mode) begin
                        if (!fifo_empty) begin
                            nxt_unit  = mk_unit({8'h00, fifo_data}, 5'd8, 1'b0, 1'b0);
                            take_byte = 1'b1;
                            use_start = 1'b1;
                            nxt_raw   = 1'b1;
                            nxt_phase = PH_BODY;
                        end
                    end else begin
                        nxt_unit  = FLAG_U;
                        use_start = 1'b1;
                        crc_seed  = 1'b1;
                        nxt_raw   = 1'b0;
                        nxt_phase = PH_BODY;
                    end
                end
            end
            PH_BODY: begin
                if (!fifo_empty) begin
                    nxt_unit  = mk_unit({8'h00, fifo_data}, 5'd8, !raw_act_q, !raw_act_q);
                    take_byte = 1'b1;
                end else if (raw_act_q) begin
                    nxt_unit  = ONES_U;
                    nxt_phase = PH_IDLE;
                end else if (fin_pend_q) begin
                    nxt_unit  = mk_unit(~crc_q, 5'd16, 1'b1, 1'b0);
                    use_fin   = 1'b1;
                    nxt_phase = PH_FCS;
                end else begin
                    nxt_unit   = ONES_U;
                    raise_urun = 1'b1;
                    nxt_phase  = PH_IDLE;
                end
            end
            PH_FCS: begin
                nxt_unit  = FLAG_U;
                nxt_phase = PH_IDLE;
            end
            default: ;
        endcase
    end

    assign stuff_now = (ones_q == 3'd5);
    assign load      = bit_en && !stuff_now && (cur_q.len == 5'd0);
    assign src       = (cur_q.len == 5'd0) ? nxt_unit : cur_q;
    assign out_bit   = src.bits[0];
    assign fifo_pop  = load && take_byte;
    assign txd       = txd_q;
    assign underrun  = urun_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            txd_q <= 1'b1;
        end else if (bit_en) begin
            txd_q <= stuff_now ? 1'b0 : out_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            cur_q        <= '0;
            phase_q      <= PH_IDLE;
            raw_act_q    <= 1'b0;
            start_pend_q <= 1'b0;
            fin_pend_q   <= 1'b0;
            ones_q       <= '0;
            crc_q        <= CRC_PRESET;
            urun_q       <= 1'b0;
        end else begin
            urun_q <= 1'b0;
            if (bit_en) begin
                if (stuff_now) begin
                    ones_q <= '0;
                end else begin
                    cur_q.bits     <= src.bits >> 1;
                    cur_q.len      <= src.len - 5'd1;
                    cur_q.stuff    <= src.stuff;
                    cur_q.fcs_feed <= src.fcs_feed;
                    ones_q         <= (src.stuff && out_bit) ? ones_q + 3'd1 : 3'd0;
                    if (load && crc_seed)  crc_q <= CRC_PRESET;
                    else if (src.fcs_feed) crc_q <= crc_step(crc_q, out_bit);
                    if (load) begin
                        phase_q   <= nxt_phase;
                        raw_act_q <= nxt_raw;
                        urun_q    <= raise_urun;
                    end
                end
            end
            // a start seen while a frame runs is a continue: nothing to latch
            if (load && use_start)
                start_pend_q <= 1'b0;
            else if (start_p && phase_q == PH_IDLE)
                start_pend_q <= 1'b1;
            // an end only counts for a framed frame that runs or is about to
            if (load && (use_fin || raise_urun))
                fin_pend_q <= 1'b0;
            else if (fin_p && ((phase_q == PH_BODY && !raw_act_q) ||
                               ((start_pend_q || start_p) && !raw_mode)))
                fin_pend_q <= 1'b1;
        end
    end

endmodule

// File: rtl/hdlc_cmd_tx.sv
module hdlc_cmd_tx
    import hdlc_tx_pkg::*;
#(
    parameter  bit WIDE_FIFO  = 1'b0,
    localparam int FIFO_DEPTH = WIDE_FIFO ? 96 : 64,
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             cmd_we,
    input  logic [2:0]       cmd_data,
    input  logic             raw_mode,
    input  logic [CNT_W-1:0] space_thr,
    input  logic             bit_en,
    output logic             txd,
    output logic             space_irq,
    output logic             underrun
);

    tx_cmd_t          cmd_q;
    logic [CNT_W-1:0] fill_cnt, free_cnt;
    logic [7:0]       fifo_data;
    logic             fifo_empty, fifo_pop;

    hdlc_cmd_reg u_cmd (
        .clk      (clk),
        .rst      (rst),
        .cmd_we   (cmd_we),
        .cmd_data (cmd_data),
        .cmd_q    (cmd_q)
    );

    tx_byte_fifo #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .flush   (cmd_q.txrst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pop     (fifo_pop),
        .rd_data (fifo_data),
        .empty   (fifo_empty),
        .fill    (fill_cnt)
    );

    hdlc_tx_serial u_ser (
        .clk        (clk),
        .rst        (rst),
        .flush      (cmd_q.txrst),
        .raw_mode   (raw_mode),
        .start_p    (cmd_q.start),
        .fin_p      (cmd_q.fin),
        .bit_en     (bit_en),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .fifo_pop   (fifo_pop),
        .txd        (txd),
        .underrun   (underrun)
    );

    assign free_cnt  = CNT_W'(FIFO_DEPTH) - fill_cnt;
    assign space_irq = (free_cnt >= space_thr);

endmodule

// File: rtl/hdlc_tx_checker.sv
module hdlc_tx_checker
    import hdlc_tx_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             bit_en,
    input logic             txd,
    input logic             underrun,
    input logic             cmd_we,
    input tx_cmd_t          cmd,
    input logic [CNT_W-1:0] fill
);

    AST_TXD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(txd)); // R12

    AST_UNDERRUN_PULSE: assert property (@(posedge clk) disable iff (rst)
        underrun |=> !underrun); // R8

    AST_CMD_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cmd != '0) && !cmd_we |=> (cmd == '0)); // R1

    AST_TXRST_FLUSH: assert property (@(posedge clk) disable iff (rst)
        cmd.txrst |=> (fill == '0)); // R9

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
        fill <= CNT_W'(DEPTH)); // R10

endmodule

bind hdlc_cmd_tx hdlc_tx_checker #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .txd      (txd),
    .underrun (underrun),
    .cmd_we   (cmd_we),
    .cmd      (cmd_q),
    .fill     (fill_cnt)
);

// File: tb/test_hdlc_cmd_tx.sv
`timescale 1ns/1ps
module test_hdlc_cmd_tx;

    localparam int DEPTH = 64;
    localparam logic [2:0] C_END = 3'b001, C_START = 3'b010, C_RST = 3'b100;

    logic       clk = 1'b0, rst = 1'b1;
    logic       wr_en = 1'b0, cmd_we = 1'b0, raw_mode = 1'b0, bit_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] cmd_data = '0;
    logic [6:0] space_thr = '0;
    logic       txd, space_irq, underrun;

    int n_cmp = 0, n_bad = 0, en_pct = 0, cyc = 0;
    int ones = 0, n_flag = 0, n_abort = 0, n_frames = 0, n_urun = 0;
    bit rec_raw = 1'b0;
    bit fbits[$];
    bit raw_bits[$];
    logic [7:0] got[$];

    hdlc_cmd_tx i_hdlc_cmd_tx (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .cmd_we(cmd_we), .cmd_data(cmd_data), .raw_mode(raw_mode),
        .space_thr(space_thr), .bit_en(bit_en), .txd(txd),
        .space_irq(space_irq), .underrun(underrun)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic end_frame();
        if (fbits.size() >= 16 && fbits.size() % 8 == 0) begin
            got.delete();
            for (int i = 0; i < fbits.size() / 8; i++) begin
                logic [7:0] b;
                for (int k = 0; k < 8; k++) b[k] = fbits[i*8 + k];
                got.push_back(b);
            end
            n_frames++;
        end
        fbits.delete();
    endtask

    // bench-side line decoder: flags, unstuffing, aborts
    task automatic rx_bit(input bit b);
        if (rec_raw) begin
            raw_bits.push_back(b);
            return;
        end
        if (b) begin
            ones++;
            fbits.push_back(1'b1);
            if (ones == 7) begin
                n_abort++;
                fbits.delete();
            end
        end else begin
            if (ones == 5) begin
                // stuffed zero dropped
            end else if (ones == 6) begin
                n_flag++;
                for (int k = 0; k < 7; k++) if (fbits.size() > 0) void'(fbits.pop_back());
                end_frame();
            end else begin
                if (ones >= 7) fbits.delete();
                fbits.push_back(1'b0);
            end
            ones = 0;
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (bit_en) rx_bit(txd);
            if (underrun) n_urun++;
        end
        bit_en = ($urandom_range(99) < en_pct);
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL all requirements: watchdog actual %0d cycles expected < 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_byte(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic command(input logic [2:0] c);
        cmd_we = 1'b1; cmd_data = c;
        tick(1);
        cmd_we = 1'b0;
    endtask

    function automatic logic [15:0] fcs_of(input logic [7:0] q[$]);
        logic [15:0] c = 16'hFFFF;
        foreach (q[i]) for (int k = 0; k < 8; k++) begin
            bit fb = c[0] ^ q[i][k];
            c = c >> 1;
            if (fb) c = c ^ 16'h8408;
        end
        return ~c;
    endfunction

    task automatic expect_frame(input logic [7:0] pl[$], input int f0, input string req);
        logic [7:0] exp[$];
        logic [15:0] f;
        int mism = 0;
        for (int i = 0; i < 6000 && n_frames == f0; i++) tick(1);
        chk(req, "frame count", n_frames, f0 + 1);
        f = fcs_of(pl);
        exp = pl;
        exp.push_back(f[7:0]);
        exp.push_back(f[15:8]);
        chk(req, "frame length", got.size(), exp.size());
        if (got.size() == exp.size())
            foreach (exp[i]) if (got[i] != exp[i]) mism++;
        chk("R4", "payload+FCS byte mismatches", mism, 0);
    endtask

    task automatic send_frame(input logic [7:0] pl[$], input bit zero_cmd, input string req);
        int f0 = n_frames;
        foreach (pl[i]) push_byte(pl[i]);
        command(C_START | C_END);
        if (zero_cmd) begin
            tick(3);
            command(3'b000);   // R1: zero bits do nothing
        end
        expect_frame(pl, f0, req);
    endtask

    initial begin
        logic [7:0] pl[$];
        int s0, u0, a0, fl0, k;
        void'($urandom(32'd24601));
        tick(4);
        rst = 1'b0;
        tick(1);
        chk("R11", "txd after reset", txd, 1);
        chk("R8", "underrun after reset", underrun, 0);

        // idle flags
        en_pct = 100;
        tick(60);
        chk("R11", "idle flags seen", n_flag >= 5, 1);
        chk("R11", "no frame while idle", n_frames, 0);

        // threshold boundaries with the line stalled
        en_pct = 0;
        tick(3);
        space_thr = 7'd60;
        for (int i = 0; i < 4; i++) push_byte(8'h11);
        tick(1);
        chk("R10", "irq free=60 thr=60", space_irq, 1);
        push_byte(8'h22);
        tick(1);
        chk("R10", "irq free=59 thr=60", space_irq, 0);
        space_thr = 7'd59;
        tick(1);
        chk("R10", "irq free=59 thr=59", space_irq, 1);
        command(C_RST);
        tick(2);
        space_thr = 7'd64;
        tick(1);
        chk("R9", "queue empty after reset cmd (irq thr=64)", space_irq, 1);
        space_thr = 7'd65;
        tick(1);
        chk("R10", "irq free=64 thr=65", space_irq, 0);
        space_thr = 7'd8;

        // directed stuffing patterns
        en_pct = 100;
        tick(20);
        pl = '{8'hFF, 8'hFF, 8'hFF, 8'hFF};
        send_frame(pl, 1'b0, "R3");
        pl = '{8'h7E, 8'h7E, 8'hF8, 8'h1F, 8'h3F};
        send_frame(pl, 1'b1, "R3");

        // one write gives one frame
        s0 = n_frames; u0 = n_urun;
        tick(400);
        chk("R1", "no repeat frame", n_frames, s0);
        chk("R1", "no spurious underrun", n_urun, u0);

        // random frames
        for (int n = 0; n < 16; n++) begin
            int len;
            en_pct = 30 + $urandom_range(70);
            tick($urandom_range(19));
            len = 1 + $urandom_range(15);
            pl.delete();
            for (int i = 0; i < len; i++)
                pl.push_back(($urandom_range(3) == 0) ? 8'hFF : 8'($urandom));
            send_frame(pl, (n % 3 == 0), "R2");
        end
        chk("R8", "no underrun on full frames", n_urun, u0);

        // continue mid-frame
        en_pct = 100;
        tick(20);
        s0 = n_frames;
        pl.delete();
        for (int i = 0; i < 12; i++) pl.push_back(8'($urandom));
        for (int i = 0; i < 6; i++) push_byte(pl[i]);
        command(C_START);
        tick(12);
        for (int i = 6; i < 12; i++) push_byte(pl[i]);
        command(C_START);
        tick(2);
        command(C_END);
        expect_frame(pl, s0, "R5");

        // end while idle is dropped; starved frame aborts
        tick(20);
        command(C_END);
        tick(60);
        s0 = n_frames; u0 = n_urun; a0 = n_abort;
        push_byte(8'h5A);
        push_byte(8'hC3);
        command(C_START);
        for (int i = 0; i < 400 && n_urun == u0; i++) tick(1);
        chk("R8", "underrun pulses", n_urun, u0 + 1);
        tick(20);
        chk("R8", "abort seen on line", n_abort, a0 + 1);
        chk("R6", "idle end did not close a frame", n_frames, s0);
        fl0 = n_flag;
        tick(60);
        chk("R8", "flags resume after abort", n_flag - fl0 >= 5, 1);

        // reset during a frame
        for (int i = 0; i < 10; i++) push_byte(8'hA0 + 8'(i));
        u0 = n_urun;
        command(C_START);
        tick(30);
        command(C_RST);
        tick(20);
        s0 = n_frames; fl0 = n_flag;
        tick(80);
        chk("R9", "no frame after reset", n_frames, s0);
        chk("R9", "flags after reset", n_flag - fl0 >= 8, 1);
        chk("R9", "no underrun from reset", n_urun, u0);
        space_thr = 7'd64;
        tick(1);
        chk("R9", "queue flushed (irq thr=64)", space_irq, 1);

        // raw mode
        raw_mode = 1'b1;
        tick(30);
        raw_bits.delete();
        rec_raw = 1'b1;
        tick(20);
        u0 = n_urun;
        pl = '{8'hFE, 8'hFF, 8'hFF, 8'h7E, 8'h00, 8'hA5};
        foreach (pl[i]) push_byte(pl[i]);
        command(C_START | C_END);
        tick(120);
        rec_raw = 1'b0;
        k = 0;
        while (k < raw_bits.size() && raw_bits[k] == 1'b1) k++;
        chk("R7", "idle ones before data", k >= 20, 1);
        begin
            int mism = 0;
            for (int i = 0; i < 48; i++)
                if (k + i >= raw_bits.size() || raw_bits[k + i] != pl[i / 8][i % 8]) mism++;
            chk("R7", "raw data bit mismatches", mism, 0);
            mism = 0;
            for (int i = k + 48; i < raw_bits.size(); i++) if (raw_bits[i] != 1'b1) mism++;
            chk("R7", "non-one bits after raw data", mism, 0);
        end
        chk("R7", "raw mode no underrun", n_urun, u0);
        chk("R7", "raw queue drained (irq thr=64)", space_irq, 1);
        raw_mode = 1'b0;
        ones = 0;
        fbits.delete();
        tick(40);
        fl0 = n_flag;
        tick(40);
        chk("R11", "flags after leaving raw", n_flag - fl0 >= 3, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule